// File: doc/BRIEF.md
# Serial DAC List Writer

This block drives a four-output serial digital-to-analog converter over a serial clock and data line that other masters also use. The converter has its own active-low select line. Software or an upstream engine hands the block an update list as a stream of bytes. The first byte is an entry count. Each entry that follows is three bytes: the value's low byte, the value's high byte, and a channel byte.

For every entry the block builds one 16-bit frame and shifts it out most significant bit first. The frame carries a 2-bit channel address, two fixed mode bits and a 12-bit value. Each frame sits inside its own select window. A single immediate update is simply a list whose count is one.

A bus-busy input lets another master keep the block off the shared lines. While that input is high, no new frame is started. A frame that has already started is always finished. The serial clock speed is set by a half-period parameter counted in system clock cycles.

Top module: `dac_list_writer`

## Requirements
- R1: Each frame is 16 bits sent MSB first. Bits 15..14 are channel byte bits 7..6. Bits 13..12 are both 1 (the mode bits). Bits 11..8 are high byte bits 3..0. Bits 7..0 are the low byte.
- R2: Bits 7..4 of the high byte and bits 5..0 of the channel byte have no effect on the frame.
- R3: dacSclk idles low and pulses high once per bit. dacDin changes only while dacSclk is low. Each high phase lasts exactly HALF_PERIOD clock cycles.
- R4: dacCsN falls before the first rising clock edge of a frame and rises only after the sixteenth falling edge. Every select window holds exactly 16 rising edges, dacSclk is never high while dacCsN is high, and dacSclk is low whenever dacCsN changes.
- R5: A list is one count byte followed by that many (low, high, channel) byte triples. Entries go out as frames in list order, one frame per entry.
- R6: A count byte of zero produces no frame, and the byte after it is taken as a new count.
- R7: Between two consecutive frames, dacCsN stays high for at least 2*HALF_PERIOD clock cycles.
- R8: dacCsN never falls in the cycle after busBusy was high. A frame that has already started completes unchanged even if busBusy rises during it.
- R9: listReady is low while dacCsN is low. listReady is high when the block waits for a list byte.
- R10: After reset, dacCsN is 1, dacSclk is 0, dacDin is 0 and listReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| listByte | input | 8 | Next byte of the update list |
| listValid | input | 1 | listByte holds a valid byte |
| listReady | output | 1 | Block accepts listByte in this cycle |
| busBusy | input | 1 | Another master owns the shared serial lines |
| dacSclk | output | 1 | Shared serial clock |
| dacDin | output | 1 | Shared serial data |
| dacCsN | output | 1 | Active-low converter select |

## Verification
The bench feeds value and channel bytes with their spare bits set. A design that masked them wrongly would corrupt the channel address or clear the mode bits, so the frame decoded from the serial lines would not match. A zero count is followed at once by a real list; a parser that skipped the zero would treat the next byte as value data and shift every later frame out of place. The bench raises busBusy before a list, to catch a select falling while another master drives the lines, and again in the middle of a frame, to catch a frame that is cut short and has the wrong bit count. Random multi-entry lists test list order and the minimum select-high gap between back-to-back frames.

// File: rtl/dac_list_pkg.sv
package dac_list_pkg;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CHAN_BITS  = 2;
  localparam int NIB_BITS   = 4;
  localparam logic [1:0] MODE_BITS = 2'b11;

  typedef enum logic [3:0] {
    S_COUNT,
    S_LOW,
    S_HIGH,
    S_CHAN,
    S_WAIT,
    S_CLKLO,
    S_CLKHI,
    S_HOLD,
    S_GAP
  } dacState_t;

  typedef struct packed {
    logic captLow;
    logic captHigh;
    logic loadFrame;
    logic shiftBit;
    logic csLow;
    logic csHigh;
    logic clkRise;
    logic clkFall;
  } dacStrobes_t;

endpackage

// File: rtl/dac_list_ctrl.sv
module dac_list_ctrl
  import dac_list_pkg::*;
#(
  parameter int HALF_PERIOD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] listByte,
  input  logic              listValid,
  input  logic              busBusy,
  output logic              listReady,
  output dacStrobes_t       strobe
);

  localparam int TW = $clog2(2 * HALF_PERIOD) + 1;
  localparam logic [TW-1:0] HALF_LOAD = TW'(HALF_PERIOD - 1);
  localparam logic [TW-1:0] GAP_LOAD  = TW'(2 * HALF_PERIOD - 1);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  dacState_t         state, stateNext;
  logic [TW-1:0]     timer, timerNext;
  logic [BW-1:0]     bitCnt, bitCntNext;
  logic [BYTE_W-1:0] remain, remainNext;
  logic              timerDone;

  assign timerDone = (timer == '0);

  always_comb begin
    stateNext  = state;
    timerNext  = timer;
    bitCntNext = bitCnt;
    remainNext = remain;
    strobe     = '0;
    listReady  = 1'b0;
    unique case (state)
      S_COUNT: begin
        listReady = 1'b1;
        if (listValid && listByte != '0) begin
          remainNext = listByte;
          stateNext  = S_LOW;
        end
      end
      S_LOW: begin
        listReady = 1'b1;
        if (listValid) begin
          strobe.captLow = 1'b1;
          stateNext      = S_HIGH;
        end
      end
      S_HIGH: begin
        listReady = 1'b1;
        if (listValid) begin
          strobe.captHigh = 1'b1;
          stateNext       = S_CHAN;
        end
      end
      S_CHAN: begin
        listReady = 1'b1;
        if (listValid) begin
          strobe.loadFrame = 1'b1;
          stateNext        = S_WAIT;
        end
      end
      S_WAIT: begin
        if (!busBusy) begin
          strobe.csLow = 1'b1;
          timerNext    = HALF_LOAD;
          bitCntNext   = '0;
          stateNext    = S_CLKLO;
        end
      end
      S_CLKLO: begin
        if (timerDone) begin
          strobe.clkRise = 1'b1;
          timerNext      = HALF_LOAD;
          stateNext      = S_CLKHI;
        end else begin
          timerNext = timer - 1'b1;
        end
      end
      S_CLKHI: begin
        if (timerDone) begin
          strobe.clkFall  = 1'b1;
          strobe.shiftBit = 1'b1;
          timerNext       = HALF_LOAD;
          bitCntNext      = bitCnt + 1'b1;
          stateNext       = (bitCnt == LAST_BIT) ? S_HOLD : S_CLKLO;
        end else begin
          timerNext = timer - 1'b1;
        end
      end
      S_HOLD: begin
        if (timerDone) begin
          strobe.csHigh = 1'b1;
          timerNext     = GAP_LOAD;
          stateNext     = S_GAP;
        end else begin
          timerNext = timer - 1'b1;
        end
      end
      S_GAP: begin
        if (timerDone) begin
          remainNext = remain - 1'b1;
          stateNext  = (remain == BYTE_W'(1)) ? S_COUNT : S_LOW;
        end else begin
          timerNext = timer - 1'b1;
        end
      end
      default: stateNext = S_COUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_COUNT;
      timer  <= '0;
      bitCnt <= '0;
      remain <= '0;
    end else begin
      state  <= stateNext;
      timer  <= timerNext;
      bitCnt <= bitCntNext;
      remain <= remainNext;
    end
  end

endmodule

// File: rtl/dac_list_datapath.sv
module dac_list_datapath
  import dac_list_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobes_t       strobe,
  input  logic [BYTE_W-1:0] listByte,
  output logic              dacSclk,
  output logic              dacDin,
  output logic              dacCsN
);

  logic [BYTE_W-1:0]     lowReg;
  logic [NIB_BITS-1:0]   highNib;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameWord;
  logic                  csReg;
  logic                  sclkReg;

  // channel field from the top bits of the channel byte, upper value nibble
  // trimmed to four bits so it cannot reach the mode or channel positions
  assign frameWord = {listByte[BYTE_W-1 -: CHAN_BITS], MODE_BITS, highNib, lowReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowReg   <= '0;
      highNib  <= '0;
      shiftReg <= '0;
    end else begin
      if (strobe.captLow)  lowReg  <= listByte;
      if (strobe.captHigh) highNib <= listByte[NIB_BITS-1:0];
      if (strobe.loadFrame)     shiftReg <= frameWord;
      else if (strobe.shiftBit) shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csReg   <= 1'b1;
      sclkReg <= 1'b0;
    end else begin
      if (strobe.csLow)        csReg <= 1'b0;
      else if (strobe.csHigh)  csReg <= 1'b1;
      if (strobe.clkRise)      sclkReg <= 1'b1;
      else if (strobe.clkFall) sclkReg <= 1'b0;
    end
  end

  assign dacCsN  = csReg;
  assign dacSclk = sclkReg;
  assign dacDin  = shiftReg[FRAME_BITS-1] & ~csReg;

endmodule

// File: rtl/dac_list_writer.sv
module dac_list_writer
  import dac_list_pkg::*;
#(
  parameter int HALF_PERIOD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] listByte,
  input  logic       listValid,
  output logic       listReady,
  input  logic       busBusy,
  output logic       dacSclk,
  output logic       dacDin,
  output logic       dacCsN
);

  dacStrobes_t strobe;

  dac_list_ctrl #(.HALF_PERIOD(HALF_PERIOD)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .listByte  (listByte),
    .listValid (listValid),
    .busBusy   (busBusy),
    .listReady (listReady),
    .strobe    (strobe)
  );

  dac_list_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .listByte (listByte),
    .dacSclk  (dacSclk),
    .dacDin   (dacDin),
    .dacCsN   (dacCsN)
  );

endmodule

// File: rtl/dac_list_writer_chk.sv
module dac_list_writer_chk #(
  parameter int HALF_PERIOD = 2
) (
  input logic clk,
  input logic rstN,
  input logic listReady,
  input logic busBusy,
  input logic dacSclk,
  input logic dacDin,
  input logic dacCsN
);

  logic [4:0] edgeCnt;
  logic [7:0] gapCnt;
  logic       sclkQ;
  logic       seenFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeCnt   <= '0;
      gapCnt    <= '0;
      sclkQ     <= 1'b0;
      seenFrame <= 1'b0;
    end else begin
      sclkQ <= dacSclk;
      if (dacCsN) edgeCnt <= '0;
      else if (dacSclk && !sclkQ) edgeCnt <= edgeCnt + 1'b1;
      if (!dacCsN) gapCnt <= '0;
      else if (gapCnt != 8'hFF) gapCnt <= gapCnt + 1'b1;
      if (!dacCsN) seenFrame <= 1'b1;
    end
  end

  assert_cs_holdoff_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dacCsN) |-> !$past(busBusy));

  assert_din_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    dacSclk |-> $stable(dacDin));

  assert_sclk_in_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    dacSclk |-> !dacCsN);

  assert_cs_moves_clk_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCsN) |-> (!dacSclk && !$past(dacSclk)));

  assert_sixteen_edges_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacCsN) |-> (edgeCnt == 5'd16));

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dacCsN) && seenFrame) |-> (gapCnt >= 8'(2 * HALF_PERIOD)));

  assert_no_accept_in_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dacCsN |-> !listReady);

endmodule

bind dac_list_writer dac_list_writer_chk #(.HALF_PERIOD(HALF_PERIOD)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .listReady (listReady),
  .busBusy   (busBusy),
  .dacSclk   (dacSclk),
  .dacDin    (dacDin),
  .dacCsN    (dacCsN)
);

// File: tb/dac_list_writer_tb_top.sv
module dac_list_writer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] listByte = '0;
  logic       listValid = 1'b0;
  logic       busBusy = 1'b0;
  logic       listReady, dacSclk, dacDin, dacCsN;

  int checks = 0;
  int errors = 0;
  logic [15:0] expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dac_list_writer #(.HALF_PERIOD(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .listByte(listByte), .listValid(listValid),
    .listReady(listReady), .busBusy(busBusy), .dacSclk(dacSclk),
    .dacDin(dacDin), .dacCsN(dacCsN)
  );

  function automatic logic [15:0] expFrame(logic [7:0] lo, logic [7:0] hi, logic [7:0] ch);
    return {ch[7:6], 2'b11, hi[3:0], lo};
  endfunction

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    while (!listReady) @(negedge clk);
    listByte  = b;
    listValid = 1'b1;
    @(negedge clk);
    listValid = 1'b0;
  endtask

  task automatic sendEntry(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] ch);
    expQ.push_back(expFrame(lo, hi, ch));
    sendByte(lo);
    sendByte(hi);
    sendByte(ch);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!(listReady && dacCsN)) @(negedge clk);
  endtask

  // serial-line monitor, sampled on the falling system clock edge
  logic        prevSclk = 1'b0, prevCs = 1'b1, prevDin = 1'b0, seen = 1'b0, dinMoved = 1'b0;
  logic [15:0] cur = '0;
  int          bitCnt = 0, highCnt = 0, gap = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevSclk && dacSclk && dacDin !== prevDin) dinMoved = 1'b1;
      if (prevCs && !dacCsN) begin
        if (seen) begin
          checks++;
          if (gap < 2 * HALF) begin
            errors++;
            $display("FAIL R7 select gap: got %0d expected >= %0d", gap, 2 * HALF);
          end
        end
        bitCnt = 0;
        cur    = '0;
      end
      if (!prevSclk && dacSclk) begin
        checks++;
        if (dacCsN) begin
          errors++;
          $display("FAIL R4 clock rise outside window: csN=%0b expected 0", dacCsN);
        end
        cur = {cur[14:0], dacDin};
        bitCnt++;
        highCnt = 0;
      end
      if (dacSclk) highCnt++;
      if (prevSclk && !dacSclk) begin
        checks++;
        if (highCnt != HALF || dinMoved) begin
          errors++;
          $display("FAIL R3 high phase: got %0d cycles dinMoved=%0b expected %0d cycles dinMoved=0",
                   highCnt, dinMoved, HALF);
        end
        dinMoved = 1'b0;
      end
      if (!prevCs && dacCsN) begin
        checks++;
        if (bitCnt != 16) begin
          errors++;
          $display("FAIL R4 clock edges in window: got %0d expected 16", bitCnt);
        end
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R5 unexpected frame: got %h expected none", cur);
        end else begin
          logic [15:0] want;
          want = expQ.pop_front();
          if (cur !== want) begin
            errors++;
            $display("FAIL R1 frame content: got %h expected %h", cur, want);
          end
        end
        seen = 1'b1;
        gap  = 0;
      end
      if (dacCsN) gap++;
      prevSclk = dacSclk;
      prevCs   = dacCsN;
      prevDin  = dacDin;
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: idle state after reset
    checks++;
    if (dacCsN !== 1'b1 || dacSclk !== 1'b0 || dacDin !== 1'b0 || listReady !== 1'b1) begin
      errors++;
      $display("FAIL R10 reset state: got cs=%0b sclk=%0b din=%0b rdy=%0b expected 1 0 0 1",
               dacCsN, dacSclk, dacDin, listReady);
    end

    // R1: single immediate write
    sendByte(8'd1);
    sendEntry(8'hA5, 8'h03, 8'h40);
    // R9: no list byte accepted while a frame is pending or running
    @(negedge clk);
    checks++;
    if (listReady !== 1'b0) begin
      errors++;
      $display("FAIL R9 ready during frame: got %0b expected 0", listReady);
    end
    waitIdle();

    // R2: spare bits of high and channel bytes set
    sendByte(8'd2);
    sendEntry(8'h00, 8'hFF, 8'h3F);
    sendEntry(8'hFF, 8'hF0, 8'hFF);
    waitIdle();

    // R6: zero count gives no frame, next byte is a count
    sendByte(8'd0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      checks++;
      if (dacCsN !== 1'b1 || listReady !== 1'b1) begin
        errors++;
        $display("FAIL R6 zero count: got cs=%0b rdy=%0b expected 1 1", dacCsN, listReady);
      end
    end
    // R5: four channels in order
    sendByte(8'd4);
    sendEntry(8'h11, 8'h01, 8'h00);
    sendEntry(8'h22, 8'h02, 8'h40);
    sendEntry(8'h33, 8'h04, 8'h80);
    sendEntry(8'h44, 8'h08, 8'hC0);
    waitIdle();

    // R8: hold-off while another master owns the lines
    busBusy = 1'b1;
    sendByte(8'd1);
    sendEntry(8'h5A, 8'h0C, 8'h80);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      checks++;
      if (dacCsN !== 1'b1) begin
        errors++;
        $display("FAIL R8 select during busy: got %0b expected 1", dacCsN);
      end
    end
    busBusy = 1'b0;
    waitIdle();

    // R8: busy rising mid-frame does not cut the frame
    sendByte(8'd1);
    sendEntry(8'hC3, 8'h09, 8'hC0);
    @(negedge clk);
    while (dacCsN) @(negedge clk);
    repeat (5) @(negedge clk);
    busBusy = 1'b1;
    waitIdle();
    busBusy = 1'b0;

    // R5 R7: random back-to-back lists
    for (int l = 0; l < 12; l++) begin
      int n;
      n = $urandom_range(1, 5);
      sendByte(8'(n));
      for (int e = 0; e < n; e++)
        sendEntry(8'($urandom), 8'($urandom), 8'($urandom));
      waitIdle();
    end

    repeat (10) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R5 missing frames: got %0d pending expected 0", expQ.size());
    end
    finishRun();
  end

endmodule